// File: doc/BRIEF.md
# Back-EMF Zero-Crossing Commutation Timer

This block paces a sensorless brushless motor drive once it runs in closed loop. A counter starts at every commutation. When the zero-crossing detector reports a crossing of the expected polarity on the undriven phase, the block stores the elapsed count. It then waits that same count again before it issues the next commutation strobe, so the crossing lands in the middle of the step. A qualified crossing that arrives unusually soon is taken as a large phase lag, and the block commutates at once. If no crossing arrives in time, the previous half-step is reused and the drive keeps turning.

Every commutation feeds the measured step length into an exponential moving average. A downstream speed loop reads this average. If no qualified crossing is accepted for a programmable number of clock cycles, the block raises a one-cycle lost-lock strobe, clears the average and halts. The supervising logic then restarts open-loop ramping and later re-arms closed loop by toggling the mode input.

Top module: `cz_commut_timer`

## Requirements
- R1: While reset is high, and in the cycle after it, `commut_o`, `lost_o` and `avg_len` are all zero.
- R2: When `closed_en` is sampled high in the off state, the block enters seeking. The step counter restarts as if a commutation had occurred on that edge, the stored half-step becomes `seed_half` (treated as 1 if zero), and `avg_len` becomes twice that value on the next cycle.
- R3: A qualified crossing sampled E cycles after the last commutation, with E not below half the stored half-step, stores E as the new half-step and produces a commutation exactly E cycles later (2E after the previous one).
- R4: A crossing is qualified only when `zc_rising` equals `expect_rising`. Any other pulse has no effect.
- R5: Crossings that arrive while a scheduled commutation is pending are ignored.
- R6: A qualified crossing sampled E cycles after the last commutation, with E strictly less than the stored half-step shifted right by one, produces a commutation on the next cycle. The stored half-step is left unchanged.
- R7: If no qualified crossing is seen, a commutation occurs when the step counter reaches twice the stored half-step.
- R8: At every commutation, `avg_len` becomes A + ((L − A) >>> AVG_K), computed as a signed value with a floor shift. A is the previous average and L is the cycles since the previous commutation (or since entry).
- R9: If `lock_timeout` cycles pass while seeking, with no accepted crossing since entry or the last accepted crossing, `lost_o` pulses for one cycle and `avg_len` reads zero. No further strobes follow until `closed_en` goes low and high again.
- R10: When `closed_en` is sampled low, the block returns to off on that edge, and no `commut_o` or `lost_o` follows, even if a commutation was pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| closed_en | input | 1 | Closed-loop mode enable |
| seed_half | input | CNT_W | Initial half-step length in cycles |
| lock_timeout | input | TO_W | Cycles without a crossing before lock is declared lost |
| zc_pulse | input | 1 | One-cycle zero-crossing detection pulse |
| zc_rising | input | 1 | Polarity of the detected crossing (1 = rising) |
| expect_rising | input | 1 | Polarity expected in the current step |
| commut_o | output | 1 | One-cycle strobe: advance commutation step |
| avg_len | output | CNT_W+1 | Averaged step length in cycles |
| lost_o | output | 1 | One-cycle strobe: lock lost |

## Verification
The main timing function is driven with four crossing patterns: none at all, a normal mid-window crossing, a crossing of the wrong polarity placed inside the early window, and a qualified early crossing. Together they separate reload pacing, mirrored scheduling, polarity filtering and immediate commutation. A stray crossing inside a pending wait shows that the schedule cannot be disturbed. A long run of reloads ends in the timeout, which shows that reload commutations do not refresh the lock watchdog. Dropping the mode input during a pending wait shows that the scheduled strobe is cancelled.

// File: rtl/cz_pkg.sv
package cz_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_SEEK = 2'd1,
    ST_WAIT = 2'd2,
    ST_HALT = 2'd3
  } cz_state_e;
endpackage

// File: rtl/cz_ema.sv
module cz_ema #(
  parameter int W = 17,
  parameter int K = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         upd,
  input  logic [W-1:0] sample,
  output logic [W-1:0] avg_o
);
  logic [W-1:0] nxt;

  generate
    if (K == 0) begin : g_direct
      assign nxt = sample;
    end else begin : g_shift
      logic signed [W:0] diff;
      logic signed [W:0] step;
      assign diff = $signed({1'b0, sample}) - $signed({1'b0, avg_o});
      assign step = diff >>> K;
      assign nxt  = avg_o + step[W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       avg_o <= '0;
    else if (load) avg_o <= load_val;
    else if (upd)  avg_o <= nxt;
  end

  AST_EMA_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> avg_o == $past(load_val)); // R2
  AST_EMA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !upd) |=> $stable(avg_o)); // R8
endmodule

// File: rtl/cz_lock_watch.sv
module cz_lock_watch #(
  parameter int TW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (clr)                cnt <= TW'(1);
    else if (run && cnt != '1)   cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= limit);

  AST_WATCH_CLR: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == TW'(1)); // R9
endmodule

// File: rtl/cz_commut_timer.sv
module cz_commut_timer
  import cz_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TO_W  = 20,
  parameter int AVG_K = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             closed_en,
  input  logic [CNT_W-1:0] seed_half,
  input  logic [TO_W-1:0]  lock_timeout,
  input  logic             zc_pulse,
  input  logic             zc_rising,
  input  logic             expect_rising,
  output logic             commut_o,
  output logic [CNT_W:0]   avg_len,
  output logic             lost_o
);
  localparam int SW = CNT_W + 1;

  cz_state_e     state;
  logic [SW-1:0] elapsed;
  logic [SW-1:0] wait_cnt;
  logic [SW-1:0] half;

  logic [SW-1:0] seed_eff;
  logic [SW:0]   full_step;
  logic          zc_ok, early, reload_hit, expired;
  logic          do_enter, do_lose, do_latch, do_early, do_reload, do_done, do_commut;
  logic          seeking;
  logic [SW-1:0] elapsed_inc;

  assign seed_eff    = (seed_half == '0) ? SW'(1) : {1'b0, seed_half};
  assign full_step   = {half, 1'b0};
  assign zc_ok       = zc_pulse && (zc_rising == expect_rising);
  assign early       = elapsed < (half >> 1);
  assign reload_hit  = {1'b0, elapsed} >= full_step;
  assign elapsed_inc = (elapsed == '1) ? elapsed : elapsed + 1'b1;

  always_comb begin
    seeking   = closed_en && (state == ST_SEEK);
    do_enter  = closed_en && (state == ST_OFF);
    do_lose   = seeking && expired;
    do_latch  = seeking && !expired && zc_ok && !early;
    do_early  = seeking && !expired && zc_ok && early;
    do_reload = seeking && !expired && !zc_ok && reload_hit;
    do_done   = closed_en && (state == ST_WAIT) && (wait_cnt <= SW'(1));
    do_commut = do_early || do_reload || do_done;
  end

  cz_ema #(.W(SW), .K(AVG_K)) ema_i (
    .clk      (clk),
    .rst      (rst),
    .load     (do_enter || do_lose),
    .load_val (do_lose ? '0 : {seed_eff[SW-2:0], 1'b0}),
    .upd      (do_commut),
    .sample   (elapsed),
    .avg_o    (avg_len)
  );

  cz_lock_watch #(.TW(TO_W)) watch_i (
    .clk     (clk),
    .rst     (rst),
    .clr     (do_enter || do_latch || do_early),
    .run     (state == ST_SEEK || state == ST_WAIT),
    .limit   (lock_timeout),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_OFF;
      elapsed  <= '0;
      wait_cnt <= '0;
      half     <= '0;
      commut_o <= 1'b0;
      lost_o   <= 1'b0;
    end else begin
      commut_o <= do_commut;
      lost_o   <= do_lose;
      if (!closed_en) begin
        state <= ST_OFF;
      end else begin
        case (state)
          ST_OFF: begin
            state   <= ST_SEEK;
            elapsed <= SW'(1);
            half    <= seed_eff;
          end
          ST_SEEK: begin
            if (do_lose) begin
              state <= ST_HALT;
            end else if (do_latch) begin
              half     <= elapsed;
              wait_cnt <= elapsed;
              elapsed  <= elapsed_inc;
              state    <= ST_WAIT;
            end else if (do_early || do_reload) begin
              elapsed <= SW'(1);
            end else begin
              elapsed <= elapsed_inc;
            end
          end
          ST_WAIT: begin
            if (do_done) begin
              elapsed <= SW'(1);
              state   <= ST_SEEK;
            end else begin
              wait_cnt <= wait_cnt - 1'b1;
              elapsed  <= elapsed_inc;
            end
          end
          default: state <= ST_HALT;
        endcase
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(commut_o && lost_o)); // R9
  AST_LOST_SINGLE: assert property (@(posedge clk) disable iff (rst)
    lost_o |=> !lost_o); // R9
  AST_LOSS_CLEARS_AVG: assert property (@(posedge clk) disable iff (rst)
    lost_o |-> avg_len == '0); // R9
  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HALT) |=> !commut_o); // R9
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !closed_en |=> (!commut_o && !lost_o)); // R10
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && wait_cnt > SW'(1)) |=> !commut_o); // R5
endmodule

// File: tb/cz_commut_timer_tb.sv
module cz_commut_timer_tb_top;
  localparam int CNT_W = 16;
  localparam int TO_W  = 20;
  localparam int AVG_K = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             closed_en = 1'b0;
  logic [CNT_W-1:0] seed_half = 16'd20;
  logic [TO_W-1:0]  lock_timeout = 20'd200;
  logic             zc_pulse = 1'b0;
  logic             zc_rising = 1'b1;
  logic             expect_rising = 1'b1;
  logic             commut_o;
  logic [CNT_W:0]   avg_len;
  logic             lost_o;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int model_avg = 0;

  int    q_cyc[$];
  int    q_kind[$];
  int    q_avg[$];
  string q_req[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cz_commut_timer #(.CNT_W(CNT_W), .TO_W(TO_W), .AVG_K(AVG_K)) dut_i (
    .clk(clk), .rst(rst), .closed_en(closed_en), .seed_half(seed_half),
    .lock_timeout(lock_timeout), .zc_pulse(zc_pulse), .zc_rising(zc_rising),
    .expect_rising(expect_rising), .commut_o(commut_o), .avg_len(avg_len),
    .lost_o(lost_o)
  );

  function automatic int ema(input int a, input int s);
    int d;
    d = s - a;
    return a + (d >>> AVG_K);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(input int c, input int kind, input int avg, input string req);
    q_cyc.push_back(c);
    q_kind.push_back(kind);
    q_avg.push_back(avg);
    q_req.push_back(req);
  endtask

  task automatic at_neg(input int n);
    do @(negedge clk); while (cyc != n);
  endtask

  task automatic crossing(input int n, input bit dir);
    at_neg(n - 1);
    zc_pulse  = 1'b1;
    zc_rising = dir;
    at_neg(n);
    zc_pulse  = 1'b0;
    zc_rising = 1'b1;
  endtask

  // monitor: pops expected strobes and compares them with what the design produces
  always @(negedge clk) begin
    if (!rst && (commut_o || lost_o)) begin
      if (q_cyc.size() == 0) begin
        check(1'b0, "R10 unexpected strobe", cyc, -1);
      end else begin
        int    ec, ek, ea;
        string er;
        int    ak;
        ec = q_cyc.pop_front();
        ek = q_kind.pop_front();
        ea = q_avg.pop_front();
        er = q_req.pop_front();
        ak = lost_o ? 1 : 0;
        check(cyc == ec, {er, " strobe cycle"}, cyc, ec);
        check(ak == ek, {er, " strobe kind"}, ak, ek);
        check(int'(avg_len) == ea, {er, " R8 average"}, int'(avg_len), ea);
      end
    end
  end

  initial begin : watchdog
    wait (cyc >= 5000);
    check(1'b0, "watchdog", cyc, 5000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    // expected schedule with seed 20, timeout 200
    model_avg = 40;
    model_avg = ema(model_avg, 40); push(50, 0, model_avg, "R7 reload");
    model_avg = ema(model_avg, 30); push(80, 0, model_avg, "R3 R4 R5 mirrored");
    model_avg = ema(model_avg, 4);  push(84, 0, model_avg, "R6 early");
    model_avg = ema(model_avg, 24); push(108, 0, model_avg, "R3 mirrored");
    for (int t = 132; t < 296; t += 24) begin
      model_avg = ema(model_avg, 24);
      push(t, 0, model_avg, "R7 reload");
    end
    push(296, 1, 0, "R9 timeout");

    at_neg(2);
    check(commut_o == 1'b0, "R1 commut in reset", int'(commut_o), 0);
    check(lost_o == 1'b0, "R1 lost in reset", int'(lost_o), 0);
    check(avg_len == '0, "R1 avg in reset", int'(avg_len), 0);
    at_neg(3);
    rst = 1'b0;
    at_neg(5);
    check(commut_o == 1'b0 && avg_len == '0, "R1 after reset", int'(avg_len), 0);

    at_neg(9);
    closed_en = 1'b1;
    at_neg(10);
    check(int'(avg_len) == 40, "R2 entry average", int'(avg_len), 40);

    crossing(55, 1'b0);   // wrong polarity inside early window (R4)
    crossing(65, 1'b1);   // mirrored, half = 15
    crossing(70, 1'b1);   // during pending wait (R5)
    crossing(84, 1'b1);   // early: 4 < 7 (R6)
    crossing(96, 1'b1);   // mirrored, half = 12

    at_neg(310);
    check(commut_o == 1'b0 && lost_o == 1'b0, "R9 halted", int'(commut_o), 0);
    at_neg(319);
    closed_en = 1'b0;

    at_neg(409);
    closed_en = 1'b1;
    at_neg(410);
    check(int'(avg_len) == 40, "R2 re-entry average", int'(avg_len), 40);
    crossing(420, 1'b1);  // would schedule strobe at 430
    at_neg(424);
    closed_en = 1'b0;
    at_neg(430);
    check(commut_o == 1'b0, "R10 pending strobe cancelled", int'(commut_o), 0);
    at_neg(470);
    check(commut_o == 1'b0 && lost_o == 1'b0, "R10 off stays quiet", int'(lost_o), 0);

    at_neg(520);
    check(q_cyc.size() == 0, "R3 R7 all expected strobes seen", q_cyc.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule